// File: doc/BRIEF.md
# General-Purpose Register File with Null Register Code

This block holds the general-purpose register state of a small datapath. There are fifteen registers, each one word wide. Each register is selected by a 4-bit identifier, and the sixteenth code (all ones) is reserved to mean "no register". Two read ports each select a register through a combinational multiplexer. Their data follows the read identifier with no clock involved. One write port loads a word into the selected register on the rising clock edge.

The write identifier is decoded into one-hot per-register load strobes, qualified by an explicit write enable, so a cycle can perform no write at all. A write to the null code stores nothing. A read of the null code returns zero. This lets instruction decode logic pass the null code on any port that a given operation does not use. A read of a register that is being written in the same cycle returns the old contents until the edge, because no write-to-read bypass is provided. A synchronous reset clears every register.

Top module: `gpr_file`

## Requirements
- R1: The file stores 15 registers of XLEN (default 64) bits at IDs 0 to 14; a read of an ID returns the last word written to it since reset.
- R2: Reads are combinational: after a read ID changes, the read data shows the selected register within the same clock cycle, with no clock edge in between.
- R3: A write takes effect only at a rising clock edge; during the cycle that presents the write, a read of the same ID still returns the previous contents.
- R4: A write changes only the register named by the write ID; every other register keeps its value.
- R5: While the write enable is low, no register changes, whatever the write ID and data are.
- R6: A write to ID 15 (4'hF, the null code) changes no register, even with the write enable high.
- R7: A read of ID 15 returns all zeros on either read port.
- R8: The two read ports are independent: both can read any IDs, including the same ID, in the same cycle as a write.
- R9: With reset high at a rising edge, all 15 registers become zero, and a write presented in that cycle is discarded.
- R10: The internal write decode raises at most one load strobe, and none when the write enable is low or the write ID is 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes and reset act on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset, clears all registers |
| wr_en_i | input | 1 | Write enable |
| wr_id_i | input | ID_W (4) | Write register ID; 15 means no register |
| wr_data_i | input | XLEN (64) | Word to be written |
| rd_a_id_i | input | ID_W (4) | Read port A register ID |
| rd_a_data_o | output | XLEN (64) | Read port A data, zero for ID 15 |
| rd_b_id_i | input | ID_W (4) | Read port B register ID |
| rd_b_data_o | output | XLEN (64) | Read port B data, zero for ID 15 |

## Verification
The hardest situation to reach from the ports is a read of the register being written in that same cycle. The read must show the old word before the edge and the new word after it, and both read ports must agree when they name the same register. The random phase draws all three IDs from a small range on many cycles so that these collisions happen often. A directed step also samples a read of the write target just before the edge and again just after it. Writes to the null code with the enable high are mixed in at a fixed rate, and a full sweep of all registers afterwards confirms that nothing moved.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int GPR_XLEN = 64;
    localparam int GPR_ID_W = 4;
    localparam int GPR_NREG = 15;
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
    parameter int ID_W = gpr_pkg::GPR_ID_W,
    parameter int NREG = gpr_pkg::GPR_NREG
) (
    input  logic            en_i,
    input  logic [ID_W-1:0] id_i,
    output logic [NREG-1:0] load_o
);
    localparam logic [ID_W-1:0] NULL_ID = '1;

    // One comparator per register; the null code never reaches a strobe.
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign load_o[g] = en_i && (id_i != NULL_ID) && (id_i == ID_W'(g));
    end
endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux #(
    parameter int XLEN = gpr_pkg::GPR_XLEN,
    parameter int ID_W = gpr_pkg::GPR_ID_W,
    parameter int NREG = gpr_pkg::GPR_NREG
) (
    input  logic [NREG-1:0][XLEN-1:0] regs_i,
    input  logic [ID_W-1:0]           id_i,
    output logic [XLEN-1:0]           data_o
);
    // AND-OR select: an unmatched ID (the null code) yields zero.
    always_comb begin
        data_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (id_i == ID_W'(i)) begin
                data_o = data_o | regs_i[i];
            end
        end
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
    parameter int XLEN = gpr_pkg::GPR_XLEN,
    parameter int ID_W = gpr_pkg::GPR_ID_W,
    parameter int NREG = gpr_pkg::GPR_NREG
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            wr_en_i,
    input  logic [ID_W-1:0] wr_id_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic [ID_W-1:0] rd_a_id_i,
    output logic [XLEN-1:0] rd_a_data_o,
    input  logic [ID_W-1:0] rd_b_id_i,
    output logic [XLEN-1:0] rd_b_data_o
);
    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
    } gpr_state_t;

    gpr_state_t      st_d, st_q;
    logic [NREG-1:0] wr_load;

    gpr_wr_decode #(.ID_W(ID_W), .NREG(NREG)) u_dec (
        .en_i   (wr_en_i),
        .id_i   (wr_id_i),
        .load_o (wr_load)
    );

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.regs = '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_load[i]) begin
                    st_d.regs[i] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    gpr_rd_mux #(.XLEN(XLEN), .ID_W(ID_W), .NREG(NREG)) u_rd_a (
        .regs_i (st_q.regs),
        .id_i   (rd_a_id_i),
        .data_o (rd_a_data_o)
    );

    gpr_rd_mux #(.XLEN(XLEN), .ID_W(ID_W), .NREG(NREG)) u_rd_b (
        .regs_i (st_q.regs),
        .id_i   (rd_b_id_i),
        .data_o (rd_b_data_o)
    );
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
    parameter int XLEN = gpr_pkg::GPR_XLEN,
    parameter int ID_W = gpr_pkg::GPR_ID_W,
    parameter int NREG = gpr_pkg::GPR_NREG
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [ID_W-1:0] wr_id,
    input logic [XLEN-1:0] wr_data,
    input logic [ID_W-1:0] rd_a_id,
    input logic [XLEN-1:0] rd_a_data,
    input logic [ID_W-1:0] rd_b_id,
    input logic [XLEN-1:0] rd_b_data,
    input logic [NREG-1:0] load
);
    localparam logic [ID_W-1:0] NULL_ID = '1;

    // R7
    null_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((rd_a_id == NULL_ID) |-> (rd_a_data == '0)) and
        ((rd_b_id == NULL_ID) |-> (rd_b_data == '0)));

    // R1
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(wr_id) != NULL_ID && rd_a_id == $past(wr_id))
        |-> (rd_a_data == $past(wr_data)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && rd_b_id == $past(rd_b_id))
        |-> (rd_b_data == $past(rd_b_data)));

    // R9
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

    // R10
    load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load));

    // R10
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_id == NULL_ID) |-> (load == '0));

    // R6
    null_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_id) == NULL_ID && rd_a_id == $past(rd_a_id))
        |-> (rd_a_data == $past(rd_a_data)));
endmodule

bind gpr_file gpr_file_chk #(.XLEN(XLEN), .ID_W(ID_W), .NREG(NREG)) chk_i (
    .clk       (clk_i),
    .rst       (rst_i),
    .wr_en     (wr_en_i),
    .wr_id     (wr_id_i),
    .wr_data   (wr_data_i),
    .rd_a_id   (rd_a_id_i),
    .rd_a_data (rd_a_data_o),
    .rd_b_id   (rd_b_id_i),
    .rd_b_data (rd_b_data_o),
    .load      (wr_load)
);

// File: tb/gpr_file_tb_top.sv
`timescale 1ns/1ps
module gpr_file_tb_top;
    localparam int XLEN = 64;
    localparam int ID_W = 4;
    localparam int NREG = 15;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [ID_W-1:0] wr_id = '0;
    logic [XLEN-1:0] wr_data = '0;
    logic [ID_W-1:0] rd_a_id = '0;
    logic [ID_W-1:0] rd_b_id = '0;
    logic [XLEN-1:0] rd_a_data, rd_b_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [XLEN-1:0] model [NREG];

    always #2.5 clk = ~clk;

    gpr_file dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_id_i(wr_id),
        .wr_data_i(wr_data), .rd_a_id_i(rd_a_id), .rd_a_data_o(rd_a_data),
        .rd_b_id_i(rd_b_id), .rd_b_data_o(rd_b_data)
    );

    function automatic logic [XLEN-1:0] exp_rd(input logic [ID_W-1:0] id);
        return (id == 4'hF) ? '0 : model[id];
    endfunction

    function automatic logic [XLEN-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive reads mid-cycle and check both ports against the model.
    task automatic read_pair(input string req, input logic [ID_W-1:0] a,
                             input logic [ID_W-1:0] b);
        rd_a_id = a;
        rd_b_id = b;
        #0.5;
        check(req, rd_a_data, exp_rd(a));
        check(req, rd_b_data, exp_rd(b));
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 16; i++) begin
            read_pair(req, ID_W'(i), ID_W'(15 - i));
        end
    endtask

    // Present a write, let one edge pass, update the model, return at negedge.
    task automatic do_write(input logic en, input logic [ID_W-1:0] id,
                            input logic [XLEN-1:0] d);
        wr_en = en; wr_id = id; wr_data = d;
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < NREG; i++) model[i] = '0;
        end else if (en && id != 4'hF) begin
            model[id] = d;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NREG; i++) model[i] = '0;
        // R9: a write during reset is discarded; all registers read zero.
        @(negedge clk);
        do_write(1'b1, 4'd3, 64'hDEAD_BEEF_0000_0003);
        do_write(1'b1, 4'd3, 64'hDEAD_BEEF_0000_0003);
        rst = 1'b0;
        sweep("R9");

        // R1 R4: boundary IDs 0 and 14, then sweep all registers.
        do_write(1'b1, 4'd0, 64'h0123_4567_89AB_CDEF);
        do_write(1'b1, 4'd14, 64'hFEDC_BA98_7654_3210);
        sweep("R4");

        // R3: same-cycle read of the write target shows the old word.
        wr_en = 1'b1; wr_id = 4'd5; wr_data = 64'hA5A5_0000_5A5A_FFFF;
        read_pair("R3", 4'd5, 4'd5);
        check("R3", rd_a_data, 64'h0);
        @(posedge clk);
        model[5] = 64'hA5A5_0000_5A5A_FFFF;
        @(negedge clk);
        wr_en = 1'b0;
        read_pair("R3", 4'd5, 4'd14);

        // R6 R7: write to the null code with enable high; null reads zero.
        do_write(1'b1, 4'hF, '1);
        sweep("R6");
        read_pair("R7", 4'hF, 4'hF);

        // R5: enable low with live data and ID changes nothing.
        do_write(1'b0, 4'd5, 64'h1111_2222_3333_4444);
        do_write(1'b0, 4'd0, '1);
        sweep("R5");

        // R2: read data follows ID changes without a clock edge.
        read_pair("R2", 4'd0, 4'd14);
        read_pair("R2", 4'd14, 4'd0);

        // R8: random traffic, IDs often colliding across the three ports.
        for (int n = 0; n < 3000; n++) begin
            logic [ID_W-1:0] wi, ai, bi;
            logic [31:0] r;
            r = $urandom();
            if (r[1:0] == 2'd0) begin
                wi = ID_W'($urandom_range(0, 3));
                ai = wi;
                bi = ID_W'($urandom_range(0, 3));
            end else begin
                wi = ID_W'($urandom_range(0, 15));
                ai = ID_W'($urandom_range(0, 15));
                bi = ID_W'($urandom_range(0, 15));
            end
            if (r[7:4] == 4'd0) wi = 4'hF;
            wr_en = r[8] | r[9];
            wr_id = wi;
            wr_data = rnd64();
            read_pair("R8", ai, bi);
            @(posedge clk);
            if (wr_en && wi != 4'hF) model[wi] = wr_data;
            @(negedge clk);
        end
        wr_en = 1'b0;
        sweep("R1");

        // R9: reset again over populated state, with a write pending.
        rst = 1'b1;
        do_write(1'b1, 4'd7, rnd64());
        rst = 1'b0;
        sweep("R9");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule